// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical sync pulses, the visible-area flag and the pixel and line positions for a video raster. Every span is a runtime input: the visible length, front porch, pulse width and back porch of each axis, and the level each sync pulse is driven to. A slow external frame store therefore needs no change to the logic when the mode changes. Modes up to 1280x720 and 1024x768 fit the default widths, as do those modes with every horizontal span doubled.

The block also pulses `fetch_go` a programmable number of clocks before a line with visible pixels starts. This gives a memory with a long read latency time to deliver the first pixel on time. The source image is normally half the screen size on both axes. In that case `pix_adv` fires on every second visible clock and `src_y` steps once per two screen lines. In full-resolution mode the host doubles the clock and all horizontal spans, and the block advances one source pixel per clock and one source row per line. A global enable stops the raster and holds it idle.

Top module: `vga_tgen`

## Requirements
- R1: On each axis, position 0 is the first visible position. The visible span comes first, then the front porch, then the sync pulse, then the back porch. `pix_x` counts 0 to htotal-1 and returns to 0, where htotal is the sum of the four horizontal spans. `pix_y` steps by one only when `pix_x` returns to 0, and it returns to 0 after vtotal lines.
- R2: `video_on` is 1 exactly when the block is enabled, `pix_x` < `h_vis` and `pix_y` < `v_vis`.
- R3: A sync pulse is asserted while the position lies in [vis+front, vis+front+sync) on its axis, so `vsync` spans whole lines. A polarity input of 0 makes the asserted level 0. A polarity input of 1 makes the asserted level 1.
- R4: With `fetch_lead` = L ≥ 1, `fetch_go` is high for the single clock at `pix_x` = htotal-L of any line whose following line (wrapping to line 0 after the last) has visible pixels. It does not fire ahead of blanking lines, and it never fires when L > htotal.
- R5: With `fetch_lead` = 0, `fetch_go` is high at `pix_x` = 0 of every line with `pix_y` < `v_vis`.
- R6: With `full_res` = 0, `pix_adv` is high on visible clocks with even `pix_x`, and `src_y` = `pix_y`/2.
- R7: With `full_res` = 1, `pix_adv` equals `video_on`, and `src_y` = `pix_y`.
- R8: While `disp_en` is 0, `video_on`, `fetch_go` and `pix_adv` are 0 and both syncs sit at their non-asserted level at once. Both positions are 0 from the next clock edge. After `disp_en` returns to 1, counting restarts from 0,0.
- R9: An active-low `rst_n` clears both positions at once, whatever the state of `disp_en`.
- R10: With default widths, a 1650-clock line and a 3300-clock line (a 1280-wide mode and the same mode doubled) keep all the behaviour above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_en | input | 1 | Global enable of the raster |
| full_res | input | 1 | 1: one source pixel per clock and per line |
| h_vis | input | HW | Horizontal visible clocks |
| h_front | input | HW | Horizontal front porch |
| h_sync | input | HW | Horizontal sync width |
| h_back | input | HW | Horizontal back porch |
| v_vis | input | VW | Visible lines |
| v_front | input | VW | Vertical front porch lines |
| v_sync | input | VW | Vertical sync lines |
| v_back | input | VW | Vertical back porch lines |
| hsync_pol | input | 1 | Asserted level of hsync |
| vsync_pol | input | 1 | Asserted level of vsync |
| fetch_lead | input | HW | Clocks between the fetch pulse and the first visible clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| video_on | output | 1 | Visible-area flag |
| fetch_go | output | 1 | Memory read start pulse |
| pix_adv | output | 1 | Source pixel advance strobe |
| pix_x | output | HW | Horizontal position |
| pix_y | output | VW | Vertical position |
| src_y | output | VW | Source row index |

## Verification
The bench builds the block with its default widths (HW = 12, VW = 10) and with half-resolution support present. Most runs use a 16-clock by 8-line raster, so every porch, both polarities, the wrap of the frame and each fetch lead case (zero, equal to the line length, beyond it) come up many times in a few hundred clocks. Two further phases run a 1650-clock line and a 3300-clock line over short frames. These show that the 12-bit horizontal counter and the wider span sums hold full-size modes, both halved and doubled.

// File: rtl/vga_tgen_pkg.sv
package vga_tgen_pkg;

   // Extra bits carried by span sums so that four maximal spans never overflow.
   localparam int unsigned SUM_GUARD = 2;

   // Per-axis zone flags, already gated by the enable.
   typedef struct packed {
      logic vis;
      logic sync;
   } axis_zone_t;

endpackage

// File: rtl/tgen_axis.sv
module tgen_axis
   import vga_tgen_pkg::*;
#(
   parameter int unsigned W = 12
)
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 step,
   input  logic [W-1:0]         len_vis,
   input  logic [W-1:0]         len_front,
   input  logic [W-1:0]         len_sync,
   input  logic [W-1:0]         len_back,
   output logic [W-1:0]         pos,
   output axis_zone_t           zone,
   output logic [W+SUM_GUARD-1:0] remain
);

   localparam int unsigned SW = W + SUM_GUARD;

   if (W < 2) begin : g_bad_width
      $error("tgen_axis: W must be at least 2");
   end

   logic [SW-1:0] pos_w;
   logic [SW-1:0] sync_lo;
   logic [SW-1:0] sync_hi;
   logic [SW-1:0] period;
   logic          at_end;

   always_comb begin
      pos_w     = SW'(pos);
      sync_lo   = SW'(len_vis) + SW'(len_front);
      sync_hi   = sync_lo + SW'(len_sync);
      period    = sync_hi + SW'(len_back);
      remain    = (pos_w >= period) ? '0 : (period - pos_w);
      at_end    = (remain <= SW'(1));
      zone.vis  = run && (pos < len_vis);
      zone.sync = run && (pos_w >= sync_lo) && (pos_w < sync_hi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos <= '0;
      else if (!run)
         pos <= '0;
      else if (step)
         pos <= at_end ? '0 : (pos + 1'b1);
   end

   assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && at_end) |=> (pos == '0));

   assert_hold_without_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step) |=> $stable(pos));

   assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pos == '0));

endmodule

// File: rtl/tgen_fetch.sv
module tgen_fetch
   import vga_tgen_pkg::*;
#(
   parameter int unsigned HW = 12,
   parameter int unsigned VW = 10
)
(
   input  logic                    run,
   input  logic [HW-1:0]           lead,
   input  logic [HW-1:0]           hpos,
   input  logic [HW+SUM_GUARD-1:0] h_remain,
   input  logic [VW-1:0]           vpos,
   input  logic [VW+SUM_GUARD-1:0] v_remain,
   input  logic [VW-1:0]           v_vis_len,
   output logic                    go
);

   localparam int unsigned HSW = HW + SUM_GUARD;

   logic [VW:0] vnext;
   logic        frame_last;
   logic        cur_vis;
   logic        next_vis;

   always_comb begin
      vnext      = {1'b0, vpos} + 1'b1;
      frame_last = (v_remain <= (VW+SUM_GUARD)'(1));
      cur_vis    = (vpos < v_vis_len);
      next_vis   = frame_last ? (v_vis_len != '0) : (vnext < {1'b0, v_vis_len});
      if (lead == '0)
         go = run && (hpos == '0) && cur_vis;
      else
         go = run && (h_remain == HSW'(lead)) && next_vis;
   end

endmodule

// File: rtl/tgen_scale.sv
module tgen_scale #(
   parameter int unsigned VW      = 10,
   parameter bit          HALF_OK = 1'b1
)
(
   input  logic          vis,
   input  logic          full,
   input  logic          hpos_lsb,
   input  logic [VW-1:0] vpos,
   output logic          adv,
   output logic [VW-1:0] src_row
);

   if (HALF_OK) begin : g_dual
      always_comb begin
         adv     = vis && (full || !hpos_lsb);
         src_row = full ? vpos : (vpos >> 1);
      end
   end else begin : g_full_only
      logic unused_sel;
      always_comb begin
         unused_sel = full ^ hpos_lsb;
         adv        = vis;
         src_row    = vpos;
      end
   end

endmodule

// File: rtl/vga_tgen.sv
module vga_tgen
   import vga_tgen_pkg::*;
#(
   parameter int unsigned HW      = 12,
   parameter int unsigned VW      = 10,
   parameter bit          HALF_OK = 1'b1
)
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disp_en,
   input  logic          full_res,
   input  logic [HW-1:0] h_vis,
   input  logic [HW-1:0] h_front,
   input  logic [HW-1:0] h_sync,
   input  logic [HW-1:0] h_back,
   input  logic [VW-1:0] v_vis,
   input  logic [VW-1:0] v_front,
   input  logic [VW-1:0] v_sync,
   input  logic [VW-1:0] v_back,
   input  logic          hsync_pol,
   input  logic          vsync_pol,
   input  logic [HW-1:0] fetch_lead,
   output logic          hsync,
   output logic          vsync,
   output logic          video_on,
   output logic          fetch_go,
   output logic          pix_adv,
   output logic [HW-1:0] pix_x,
   output logic [VW-1:0] pix_y,
   output logic [VW-1:0] src_y
);

   localparam int unsigned HSW = HW + SUM_GUARD;
   localparam int unsigned VSW = VW + SUM_GUARD;

   if (HW < 11) begin : g_hw_small
      $error("vga_tgen: HW below 11 cannot hold wide modes");
   end
   if (VW < 10) begin : g_vw_small
      $error("vga_tgen: VW below 10 cannot hold 768 lines");
   end

   axis_zone_t      h_zone;
   axis_zone_t      v_zone;
   logic [HSW-1:0]  h_remain;
   logic [VSW-1:0]  v_remain;
   logic            line_end;

   assign line_end = (h_remain <= HSW'(1));

   tgen_axis #(.W(HW)) i_h_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (disp_en),
      .step      (1'b1),
      .len_vis   (h_vis),
      .len_front (h_front),
      .len_sync  (h_sync),
      .len_back  (h_back),
      .pos       (pix_x),
      .zone      (h_zone),
      .remain    (h_remain)
   );

   tgen_axis #(.W(VW)) i_v_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (disp_en),
      .step      (line_end),
      .len_vis   (v_vis),
      .len_front (v_front),
      .len_sync  (v_sync),
      .len_back  (v_back),
      .pos       (pix_y),
      .zone      (v_zone),
      .remain    (v_remain)
   );

   tgen_fetch #(.HW(HW), .VW(VW)) i_fetch (
      .run       (disp_en),
      .lead      (fetch_lead),
      .hpos      (pix_x),
      .h_remain  (h_remain),
      .vpos      (pix_y),
      .v_remain  (v_remain),
      .v_vis_len (v_vis),
      .go        (fetch_go)
   );

   tgen_scale #(.VW(VW), .HALF_OK(HALF_OK)) i_scale (
      .vis      (video_on),
      .full     (full_res),
      .hpos_lsb (pix_x[0]),
      .vpos     (pix_y),
      .adv      (pix_adv),
      .src_row  (src_y)
   );

   always_comb begin
      video_on = h_zone.vis && v_zone.vis;
      hsync    = hsync_pol ? h_zone.sync : !h_zone.sync;
      vsync    = vsync_pol ? v_zone.sync : !v_zone.sync;
   end

   assert_line_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && !line_end) |=> $stable(pix_y));

   assert_sync_outside_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
      video_on |-> (!h_zone.sync && !v_zone.sync));

   assert_zero_lead_in_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_go && (fetch_lead == '0) && (h_vis != '0)) |-> video_on);

   assert_adv_in_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_adv |-> video_on);

   assert_src_row_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en |-> (src_y <= pix_y));

   assert_disabled_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |=> ((pix_x == '0) && (pix_y == '0)));

endmodule

// File: tb/test_vga_tgen.sv
module test_vga_tgen;

   localparam int HW = 12;
   localparam int VW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          disp_en = 1'b0;
   logic          full_res = 1'b0;
   logic [HW-1:0] h_vis, h_front, h_sync, h_back, fetch_lead;
   logic [VW-1:0] v_vis, v_front, v_sync, v_back;
   logic          hsync_pol = 1'b0;
   logic          vsync_pol = 1'b0;
   logic          hsync, vsync, video_on, fetch_go, pix_adv;
   logic [HW-1:0] pix_x;
   logic [VW-1:0] pix_y, src_y;

   vga_tgen #(.HW(HW), .VW(VW), .HALF_OK(1'b1)) i_vga_tgen (
      .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .full_res(full_res),
      .h_vis(h_vis), .h_front(h_front), .h_sync(h_sync), .h_back(h_back),
      .v_vis(v_vis), .v_front(v_front), .v_sync(v_sync), .v_back(v_back),
      .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .fetch_lead(fetch_lead),
      .hsync(hsync), .vsync(vsync), .video_on(video_on), .fetch_go(fetch_go),
      .pix_adv(pix_adv), .pix_x(pix_x), .pix_y(pix_y), .src_y(src_y)
   );

   always #5 clk = ~clk;

   typedef struct {
      int x; int y; int sy;
      bit vis; bit hs; bit vs; bit go; bit adv;
      bit rst; bit en; bit wide; bit full; bit lead0;
   } exp_t;

   exp_t sb[$];
   int   mh = 0;
   int   mv = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   wide_phase = 1'b0;
   bit   done = 1'b0;

   function automatic int htot();
      return int'(h_vis) + int'(h_front) + int'(h_sync) + int'(h_back);
   endfunction

   function automatic int vtot();
      return int'(v_vis) + int'(v_front) + int'(v_sync) + int'(v_back);
   endfunction

   // Reference raster position, built from R1, R8 and R9.
   always @(posedge clk) begin
      if (!rst_n || !disp_en) begin
         mh = 0;
         mv = 0;
      end else begin
         mh++;
         if (mh >= htot()) begin
            mh = 0;
            mv++;
            if (mv >= vtot()) mv = 0;
         end
      end
   end

   task automatic predict_push();
      exp_t e;
      int x, y, lo, hi, nv;
      bit hs_a, vs_a;
      x = rst_n ? mh : 0;
      y = rst_n ? mv : 0;
      e.rst = !rst_n; e.en = disp_en; e.wide = wide_phase;
      e.full = full_res; e.lead0 = (fetch_lead == '0);
      e.x = x; e.y = y;
      e.vis = disp_en && (x < int'(h_vis)) && (y < int'(v_vis));
      lo = int'(h_vis) + int'(h_front); hi = lo + int'(h_sync);
      hs_a = disp_en && (x >= lo) && (x < hi);
      e.hs = hsync_pol ? hs_a : !hs_a;
      lo = int'(v_vis) + int'(v_front); hi = lo + int'(v_sync);
      vs_a = disp_en && (y >= lo) && (y < hi);
      e.vs = vsync_pol ? vs_a : !vs_a;
      nv = (y >= vtot() - 1) ? 0 : y + 1;
      if (fetch_lead == '0)
         e.go = disp_en && (x == 0) && (y < int'(v_vis));
      else
         e.go = disp_en && (x == htot() - int'(fetch_lead)) && (nv < int'(v_vis));
      e.adv = e.vis && (full_res || (x % 2 == 0));
      e.sy = full_res ? y : y / 2;
      sb.push_back(e);
   endtask

   always @(negedge clk) begin
      #1;
      predict_push();
   end

   task automatic chk(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string tag_of(exp_t e, string field_tag);
      string t;
      if (e.rst) t = "R9";
      else if (!e.en) t = "R8";
      else t = field_tag;
      if (e.wide) t = {"R10/", t};
      return t;
   endfunction

   always @(negedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(tag_of(e, "R1"), "pix_x", int'(pix_x), e.x);
         chk(tag_of(e, "R1"), "pix_y", int'(pix_y), e.y);
         chk(tag_of(e, "R2"), "video_on", int'(video_on), int'(e.vis));
         chk(tag_of(e, "R3"), "hsync", int'(hsync), int'(e.hs));
         chk(tag_of(e, "R3"), "vsync", int'(vsync), int'(e.vs));
         chk(tag_of(e, e.lead0 ? "R5" : "R4"), "fetch_go", int'(fetch_go), int'(e.go));
         chk(tag_of(e, e.full ? "R7" : "R6"), "pix_adv", int'(pix_adv), int'(e.adv));
         chk(tag_of(e, e.full ? "R7" : "R6"), "src_y", int'(src_y), e.sy);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_h(int a, int b, int c, int d);
      h_vis = HW'(a); h_front = HW'(b); h_sync = HW'(c); h_back = HW'(d);
   endtask

   task automatic set_v(int a, int b, int c, int d);
      v_vis = VW'(a); v_front = VW'(b); v_sync = VW'(c); v_back = VW'(d);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin
      rst_n = 1'b0;
      set_h(8, 2, 3, 3);
      set_v(4, 1, 2, 1);
      fetch_lead = HW'(3);
      hsync_pol = 1'b0; vsync_pol = 1'b1; full_res = 1'b0; disp_en = 1'b0;
      cyc(4);
      rst_n = 1'b1;                       // R9: reset state observed above
      cyc(3);
      disp_en = 1'b1;                     // R1-style raster, half res, lead 3 (R4, R6)
      cyc(300);
      disp_en = 1'b0;                     // R8: stop mid-frame
      cyc(10);
      disp_en = 1'b1;
      cyc(200);
      rst_n = 1'b0;                       // R9: reset while enabled
      cyc(3);
      rst_n = 1'b1;
      cyc(50);
      disp_en = 1'b0; cyc(2);
      full_res = 1'b1; fetch_lead = '0;   // R5, R7, flipped polarities (R3)
      hsync_pol = 1'b1; vsync_pol = 1'b0;
      disp_en = 1'b1;
      cyc(300);
      disp_en = 1'b0; cyc(2);
      fetch_lead = HW'(16);               // R4: lead equal to line length
      disp_en = 1'b1;
      cyc(150);
      disp_en = 1'b0; cyc(2);
      fetch_lead = HW'(20);               // R4: lead beyond line length
      full_res = 1'b0;
      disp_en = 1'b1;
      cyc(150);
      disp_en = 1'b0; cyc(2);
      wide_phase = 1'b1;                  // R10: 1650-clock line
      set_h(1280, 110, 40, 220);
      set_v(3, 1, 1, 1);
      fetch_lead = HW'(100);
      hsync_pol = 1'b0; vsync_pol = 1'b0;
      disp_en = 1'b1;
      cyc(1650 * 5 + 60);
      disp_en = 1'b0; cyc(2);
      full_res = 1'b1;                    // R10: doubled 3300-clock line
      set_h(2560, 220, 80, 440);
      disp_en = 1'b1;
      cyc(3300 * 5 + 60);
      disp_en = 1'b0;
      cyc(5);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog run did not finish");
         summary();
         $finish;
      end
   end

endmodule